// File: doc/BRIEF.md
# Stepped Counter and Pseudo-Random Stream Checker

This block watches a received stream of test words and reports, bit by bit, where the stream departed from the pattern it should follow. Two patterns are known. The first is a counter. The second is a maximal-length pseudo-random sequence. A select input chooses between them. Every expectation is formed from the word received just before, so the checker locks on at once and locks on again after a disturbance.

In counter mode a build with stepping enabled accepts a word when its distance from the previous word equals any one of a small set of programmable step values. This lets it verify counters that advance by values other than +1, including zero and negative steps. A build without stepping accepts only +1.

The result holds the OR of all per-bit mismatches seen since the last clear. It has one extra top bit that marks "nothing received yet". A result of all zeros means the stream followed its pattern.

Top module: `seq_step_checker`

## Requirements
- R1: `cnt_sel_i` = 1 selects counter checking and 0 selects pseudo-random checking. `res_o` is DATA_W+1 bits wide: bit DATA_W is the no-word-seen flag and bits DATA_W-1:0 are the accumulated mismatch bits. A correctly incrementing (+1) counter stream leaves the mismatch bits at zero.
- R2: While and directly after reset, `res_o` is 1 followed by DATA_W zeros, and `res_valid_o` is 0.
- R3: With USE_STEPS=1 in counter mode, a word is accepted when (word − previous word) mod 2^DATA_W equals any step slot. Slot k sits at `steps_i[k*DATA_W +: DATA_W]`, taken modulo 2^DATA_W, so zero and negative steps are allowed. Arithmetic wraps at 2^DATA_W.
- R4: With USE_STEPS=0 in counter mode, only a difference of exactly +1 is accepted, whatever `steps_i` holds.
- R5: A word that is not accepted ORs (word XOR expected) into the mismatch bits. The expected value is previous+slot 0 in a stepping build and previous+1 otherwise. Mismatch bits never clear while checking continues.
- R6: A word presented with `in_valid_i` at clock edge k changes `res_o` at edge k+1 and not earlier.
- R7: The expectation always comes from the previous received word, including a bad one. A stream that resumes correct stepping from the bad word adds no further mismatch bits.
- R8: With USE_STEPS=0 in pseudo-random mode, the expected word is {prev[DATA_W-2:0], ^(prev & MASK)}, where MASK is 16'hD008 for 16 bits and 8'hB8 for 8 bits. A correct stream leaves the mismatch bits at zero.
- R9: With USE_STEPS=1 in pseudo-random mode, every accepted word sets all mismatch bits to one and the top bit reads 0.
- R10: After a clear, the top bit stays 1 until the first valid word takes effect (edge k+1 as in R6). It then reads 0.
- R11: At an edge where `en_i` is 0, or where `cnt_sel_i` differs from its value at the previous edge, the block clears. The result returns to the R2 value, the previous word and any word in flight are forgotten, and `res_valid_o` is 0 until the next edge. A clear wins over a word in flight at the same edge.
- R12: Cycles with `in_valid_i` low have no effect on the result or on the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Checking enable; low clears |
| cnt_sel_i | input | 1 | 1 = counter pattern, 0 = pseudo-random pattern |
| in_valid_i | input | 1 | Qualifies `in_data_i` |
| in_data_i | input | DATA_W | Received test word |
| steps_i | input | NUM_STEPS*DATA_W | Allowed counter steps, slot k at bits k*DATA_W |
| res_o | output | DATA_W+1 | {no-word-seen flag, accumulated mismatch bits} |
| res_valid_o | output | 1 | Result reflects an uninterrupted run |

## Verification
Two events can meet at one edge. A word already captured may be about to fold into the result just as a clear arrives, either from enable dropping or from the mode select flipping. The bench provokes this by presenting a bad word and then removing enable, or switching mode, on the very next cycle. It judges the result by requiring the cleared value with the top bit set and no trace of the bad word. The same clock-by-clock model also covers the first word after a clear, where the top flag falls in the same cycle that the previous-word register is loaded.

// File: rtl/seq_chk_pkg.sv
package seq_chk_pkg;

    typedef enum logic {
        MODE_PRSG = 1'b0,
        MODE_CNT  = 1'b1
    } seq_mode_e;

    // Feedback tap mask of a maximal-length shift register, bit i = tap i+1.
    function automatic logic [31:0] lfsr_tap_mask(input int unsigned width);
        case (width)
            4:       return 32'h0000_000C;
            8:       return 32'h0000_00B8;
            12:      return 32'h0000_0E08;
            16:      return 32'h0000_D008;
            24:      return 32'h00E1_0000;
            32:      return 32'h8020_0003;
            default: return 32'h3 << (width - 2);
        endcase
    endfunction

endpackage

// File: rtl/seq_lfsr_predict.sv
module seq_lfsr_predict
    import seq_chk_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] prev_i,
    output logic [DATA_W-1:0] next_o
);
    localparam logic [31:0]       MASK_FULL = lfsr_tap_mask(DATA_W);
    localparam logic [DATA_W-1:0] TAP_MASK  = MASK_FULL[DATA_W-1:0];

    assign next_o = {prev_i[DATA_W-2:0], ^(prev_i & TAP_MASK)};
endmodule

// File: rtl/seq_step_match.sv
module seq_step_match #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_STEPS = 4
) (
    input  logic [DATA_W-1:0]           prev_i,
    input  logic [DATA_W-1:0]           cur_i,
    input  logic [NUM_STEPS*DATA_W-1:0] steps_i,
    output logic [DATA_W-1:0]           mism_o
);
    logic [DATA_W-1:0]    delta;
    logic [NUM_STEPS-1:0] hit;

    assign delta = cur_i - prev_i;

    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_slot
        assign hit[k] = (delta == steps_i[k*DATA_W +: DATA_W]);
    end

    // On a miss, report the difference against slot 0 as the bit pattern.
    assign mism_o = (|hit) ? '0 : (cur_i ^ (prev_i + steps_i[DATA_W-1:0]));
endmodule

// File: rtl/seq_step_checker.sv
module seq_step_checker
    import seq_chk_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_STEPS = 4,
    parameter bit          USE_STEPS = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en_i,
    input  logic                        cnt_sel_i,
    input  logic                        in_valid_i,
    input  logic [DATA_W-1:0]           in_data_i,
    input  logic [NUM_STEPS*DATA_W-1:0] steps_i,
    output logic [DATA_W:0]             res_o,
    output logic                        res_valid_o
);
    localparam logic [DATA_W-1:0] STEP_ONE = DATA_W'(1);

    typedef struct packed {
        seq_mode_e         sel;
        logic              run;
        logic              pend_vld;
        logic [DATA_W-1:0] pend_dat;
        logic              have_prev;
        logic [DATA_W-1:0] prev;
        logic [DATA_W-1:0] err;
        logic              idle;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_STEPS*DATA_W-1:0] eff_steps;
    logic [DATA_W-1:0]           cnt_mism;
    logic [DATA_W-1:0]           prsg_exp;
    logic [DATA_W-1:0]           word_mism;
    logic                        clr;

    // A build without stepping sees +1 in every slot: plain counter check.
    if (USE_STEPS) begin : g_prog_steps
        assign eff_steps = steps_i;
    end else begin : g_unit_step
        assign eff_steps = {NUM_STEPS{STEP_ONE}};
    end

    seq_step_match #(
        .DATA_W    (DATA_W),
        .NUM_STEPS (NUM_STEPS)
    ) u_match (
        .prev_i  (st_q.prev),
        .cur_i   (st_q.pend_dat),
        .steps_i (eff_steps),
        .mism_o  (cnt_mism)
    );

    seq_lfsr_predict #(
        .DATA_W (DATA_W)
    ) u_predict (
        .prev_i (st_q.prev),
        .next_o (prsg_exp)
    );

    always_comb begin
        st_d = st_q;
        clr  = !en_i || (seq_mode_e'(cnt_sel_i) != st_q.sel);

        if (st_q.sel == MODE_CNT) begin
            word_mism = st_q.have_prev ? cnt_mism : '0;
        end else if (USE_STEPS) begin
            word_mism = '1;
        end else begin
            word_mism = st_q.have_prev ? (st_q.pend_dat ^ prsg_exp) : '0;
        end

        st_d.sel = seq_mode_e'(cnt_sel_i);
        st_d.run = !clr;

        if (clr) begin
            st_d.pend_vld  = 1'b0;
            st_d.have_prev = 1'b0;
            st_d.err       = '0;
            st_d.idle      = 1'b1;
        end else begin
            st_d.pend_vld = in_valid_i;
            if (in_valid_i) begin
                st_d.pend_dat = in_data_i;
            end
            if (st_q.pend_vld) begin
                st_d.err       = st_q.err | word_mism;
                st_d.idle      = 1'b0;
                st_d.prev      = st_q.pend_dat;
                st_d.have_prev = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel       <= MODE_CNT;
            st_q.run       <= 1'b0;
            st_q.pend_vld  <= 1'b0;
            st_q.pend_dat  <= '0;
            st_q.have_prev <= 1'b0;
            st_q.prev      <= '0;
            st_q.err       <= '0;
            st_q.idle      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o       = {st_q.idle, st_q.err};
    assign res_valid_o = st_q.run;
endmodule

// File: rtl/seq_step_checker_sva.sv
module seq_step_checker_sva #(
    parameter int unsigned DATA_W    = 16,
    parameter bit          USE_STEPS = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              cnt_sel_i,
    input logic [DATA_W:0]   res_o,
    input logic              res_valid_o
);
    localparam logic [DATA_W:0] CLEARED = {1'b1, {DATA_W{1'b0}}};

    p_reset_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (res_o == CLEARED && !res_valid_o));

    p_enable_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (res_o == CLEARED && !res_valid_o));

    p_mode_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (cnt_sel_i != $past(cnt_sel_i))) |=> (res_o == CLEARED));

    p_sticky_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $stable(cnt_sel_i)) |=>
            ((res_o[DATA_W-1:0] & $past(res_o[DATA_W-1:0])) == $past(res_o[DATA_W-1:0])));

    p_flag_falls_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(res_o[DATA_W]) |-> $past(en_i));

    if (USE_STEPS) begin : g_steps
        p_prsg_all_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid_o && !res_o[DATA_W] && !$past(cnt_sel_i)) |-> (&res_o[DATA_W-1:0]));
    end
endmodule

bind seq_step_checker seq_step_checker_sva #(
    .DATA_W    (DATA_W),
    .USE_STEPS (USE_STEPS)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .cnt_sel_i   (cnt_sel_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o)
);

// File: tb/seq_step_checker_bench.sv
module seq_step_checker_bench;
    localparam int W = 16;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic sel = 1'b1;
    logic vld = 1'b0;
    logic [W-1:0] dat = '0;
    logic [W-1:0] stp [N] = '{16'd1, 16'd0, 16'hFFF9, 16'd3};
    logic [N*W-1:0] steps_vec;
    logic [W:0] res_s, res_p;
    logic val_s, val_p;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R2";

    assign steps_vec = {stp[3], stp[2], stp[1], stp[0]};

    always #5 clk = ~clk;

    seq_step_checker #(.DATA_W(W), .NUM_STEPS(N), .USE_STEPS(1'b1)) u_seq_step_checker (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cnt_sel_i(sel), .in_valid_i(vld),
        .in_data_i(dat), .steps_i(steps_vec), .res_o(res_s), .res_valid_o(val_s));

    seq_step_checker #(.DATA_W(W), .NUM_STEPS(N), .USE_STEPS(1'b0)) u_seq_step_checker_plain (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cnt_sel_i(sel), .in_valid_i(vld),
        .in_data_i(dat), .steps_i(steps_vec), .res_o(res_p), .res_valid_o(val_p));

    function automatic logic [W-1:0] ref_prsg(input logic [W-1:0] x);
        return {x[W-2:0], x[15] ^ x[14] ^ x[12] ^ x[3]};
    endfunction

    // Reference model: index 0 = stepping build, index 1 = plain build
    logic         m_sel, m_run, m_have, m_idle, m_clr, m_hit;
    logic [W-1:0] m_prev, m_word, m_diff;
    logic [W-1:0] m_err [2];
    logic [W-1:0] pq [$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_sel = 1'b1; m_run = 1'b0; m_have = 1'b0; m_idle = 1'b1;
            m_prev = '0; m_err[0] = '0; m_err[1] = '0; pq.delete();
        end else begin
            m_clr = !en || (sel != m_sel);
            if (m_clr) begin
                pq.delete(); m_have = 1'b0; m_idle = 1'b1;
                m_err[0] = '0; m_err[1] = '0;
            end else begin
                if (pq.size() > 0) begin
                    m_word = pq.pop_front();
                    if (sel) begin
                        if (m_have) begin
                            m_diff = m_word - m_prev;
                            m_hit = 1'b0;
                            foreach (stp[k]) if (m_diff == stp[k]) m_hit = 1'b1;
                            if (!m_hit) m_err[0] |= m_word ^ (m_prev + stp[0]);
                            if (m_diff != 16'd1) m_err[1] |= m_word ^ (m_prev + 16'd1);
                        end
                    end else begin
                        m_err[0] = '1;
                        if (m_have) m_err[1] |= m_word ^ ref_prsg(m_prev);
                    end
                    m_idle = 1'b0; m_prev = m_word; m_have = 1'b1;
                end
                if (vld) pq.push_back(dat);
            end
            m_run = !m_clr;
            m_sel = sel;
        end
        if (cyc == 50000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Clock-by-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " stepping result"}, res_s, {m_idle, m_err[0]});
            chk({cur_req, " plain result"}, res_p, {m_idle, m_err[1]});
            chk({cur_req, " stepping valid"}, {{W{1'b0}}, val_s}, {{W{1'b0}}, m_run});
            chk({cur_req, " plain valid"}, {{W{1'b0}}, val_p}, {{W{1'b0}}, m_run});
        end
    end

    task automatic send(input logic v, input logic [W-1:0] d);
        @(negedge clk);
        vld = v;
        dat = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(1'b0, 16'hDEAD);
    endtask

    task automatic pulse_clear;
        @(negedge clk);
        vld = 1'b0; en = 1'b0;
        @(negedge clk);
        en = 1'b1;
    endtask

    localparam logic [W:0] CLR_VAL = {1'b1, {W{1'b0}}};

    initial begin
        logic [W-1:0] p;
        repeat (4) @(negedge clk);
        chk("R2 reset stepping", res_s, CLR_VAL);
        chk("R2 reset plain", res_p, CLR_VAL);
        rst_n = 1'b1;

        // R1: plain +1 counter
        cur_req = "R1";
        @(negedge clk); en = 1'b1; sel = 1'b1;
        for (int i = 0; i < 10; i++) send(1'b1, 16'(100 + i));
        idle(3);
        chk("R1 counter ok stepping", res_s, '0);
        chk("R1 counter ok plain", res_p, '0);

        // R3 / R4: zero, negative and positive steps
        cur_req = "R11"; pulse_clear();
        cur_req = "R3";
        send(1, 500); send(1, 500); send(1, 493); send(1, 496); send(1, 497);
        idle(3);
        chk("R3 steps accepted", res_s, '0);
        cur_req = "R4";
        checks++;
        if (res_p[W-1:0] == '0) begin
            errors++;
            $display("FAIL R4 actual=%h expected=nonzero", res_p);
        end

        // R12: gaps with junk data
        cur_req = "R11"; pulse_clear();
        cur_req = "R12";
        send(1, 10); send(0, 999); send(1, 11); send(0, 5); send(0, 77); send(1, 12);
        idle(3);
        chk("R12 gaps stepping", res_s, '0);
        chk("R12 gaps plain", res_p, '0);

        // R5 / R6 / R7: bad word, latency, relock
        cur_req = "R11"; pulse_clear();
        cur_req = "R6";
        send(1, 20); send(1, 21); send(1, 16'h0055);
        send(0, 0);
        chk("R6 not yet visible", res_s, '0);
        @(negedge clk);
        cur_req = "R5";
        chk("R5 mismatch bits", res_s, {1'b0, 16'h0055 ^ 16'd22});
        cur_req = "R7";
        send(1, 16'h0056); send(1, 16'h0057);
        idle(3);
        chk("R7 relock stepping", res_s, {1'b0, 16'h0055 ^ 16'd22});
        chk("R7 relock plain", res_p, {1'b0, 16'h0055 ^ 16'd22});

        // R11: clear wins over a word in flight
        cur_req = "R11";
        send(1, 16'h1234);
        @(negedge clk); vld = 1'b0; en = 1'b0;
        @(negedge clk);
        chk("R11 enable clear", res_s, CLR_VAL);
        chk("R11 enable valid low", {{W{1'b0}}, val_s}, '0);
        en = 1'b1;

        // R8 / R9: pseudo-random mode, entered by a mode switch
        @(negedge clk); sel = 1'b0;
        @(negedge clk);
        chk("R11 mode clear", res_p, CLR_VAL);
        cur_req = "R8";
        p = 16'hACE1;
        for (int i = 0; i < 12; i++) begin
            send(1, p);
            p = ref_prsg(p);
        end
        idle(3);
        chk("R8 prsg ok plain", res_p, '0);
        cur_req = "R9";
        chk("R9 prsg in stepping build", res_s, {1'b0, {W{1'b1}}});
        cur_req = "R8";
        send(1, p ^ 16'h0100);
        idle(3);
        chk("R8 prsg error plain", res_p, {1'b0, 16'h0100});

        // R11: mode switch while a word is in flight
        cur_req = "R11";
        send(1, 16'h4444);
        @(negedge clk); vld = 1'b0; sel = 1'b1;
        @(negedge clk);
        chk("R11 switch drops word", res_p, CLR_VAL);

        // R3: wrap-around
        cur_req = "R3";
        send(1, 16'hFFFE); send(1, 16'hFFFF); send(1, 16'h0000);
        send(1, 16'hFFF9); send(1, 16'hFFFC); send(1, 16'hFFFC); send(1, 16'hFFFD);
        idle(3);
        chk("R3 wrap stepping", res_s, '0);

        // R10: flag stays high until the first word takes effect
        cur_req = "R11"; pulse_clear();
        cur_req = "R10";
        idle(3);
        chk("R10 flag while empty", res_s, CLR_VAL);
        send(1, 16'h0300);
        send(0, 0);
        chk("R10 flag one edge later", res_s, CLR_VAL);
        @(negedge clk);
        chk("R10 flag cleared", res_s, '0);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule